// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address presented to a pipelined synchronous burst memory array. A start address is captured from the address bus whenever one of two active-low address strobes is seen at a rising clock edge. One strobe comes from a cache controller and is always honoured. The other comes from a processor and is honoured only while the chip enable is low. After the capture, the two least significant address bits walk through a four-beat burst while the active-low advance input is held low. All higher bits stay fixed at the captured value.

The beat order is set by a static select input. When it is high, the order is interleaved: the low bits are the start bits XOR a 2-bit beat count. When it is low, the order is linear: the low bits are the start bits plus the beat count, modulo four. When advance is high, the beat count holds and the burst pauses on its current address. After the fourth beat the count wraps to the start value, and no carry reaches the upper bits. The output follows the internal registers, so a load or a step is visible just after the clock edge that causes it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and just after it is released, `wordAddr` is zero.
- R2: A clock edge with `ctrlStrobeN` low loads `addrIn` into `wordAddr` whatever the level of `chipEnN`.
- R3: A clock edge with `procStrobeN` low loads `addrIn` only if `chipEnN` is low; with `chipEnN` high and `ctrlStrobeN` high, `wordAddr` is left unchanged.
- R4: At a clock edge with no load and `advanceN` low, the beat count steps by one.
- R5: At a clock edge with no load and `advanceN` high, `wordAddr` keeps its value.
- R6: With `interleaveSel` = 1, `wordAddr[1:0]` equals start[1:0] XOR count; a start of 01 gives 01, 00, 11, 10.
- R7: With `interleaveSel` = 0, `wordAddr[1:0]` equals (start[1:0] + count) mod 4; a start of 10 gives 10, 11, 00, 01.
- R8: After the fourth beat the sequence returns to the start address. `wordAddr[14:2]` never changes without a load, so no carry reaches bit 2.
- R9: A load at the same edge as an active advance wins. `wordAddr` becomes `addrIn` exactly, with the beat count cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addrIn | input | 15 | Start address bus |
| procStrobeN | input | 1 | Processor address strobe, active low, gated by chip enable |
| ctrlStrobeN | input | 1 | Controller address strobe, active low, not gated |
| chipEnN | input | 1 | Chip enable, active low |
| advanceN | input | 1 | Burst advance, active low |
| interleaveSel | input | 1 | Static order select: 1 interleaved, 0 linear |
| wordAddr | output | 15 | Current array word address |

## Verification
The checker tests several rules on every edge:
- either strobe load captures the bus value;
- a gated processor strobe leaves the address alone;
- the address holds while advance is high;
- the upper bits never move between loads;
- in linear order, each advance adds one to the low bits.

Some behaviour cannot be seen from the ports in a single cycle, because the beat count is hidden. This covers the interleaved visiting order, the wrap back to the start after four beats, and priority resuming from beat zero. Directed bench scenarios show these by following whole bursts from known start addresses.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Control strobes handed from the decode stage to the datapath.
  typedef struct packed {
    logic loadEn;  // capture a new start address, clear the beat count
    logic stepEn;  // advance the beat count by one
  } burstCtrl_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic       procStrobeN,
  input  logic       ctrlStrobeN,
  input  logic       chipEnN,
  input  logic       advanceN,
  output burstCtrl_t ctrlOut
);
  logic procLoad;
  logic ctrlLoad;

  always_comb begin
    procLoad       = ~procStrobeN & ~chipEnN;
    ctrlLoad       = ~ctrlStrobeN;
    ctrlOut.loadEn = procLoad | ctrlLoad;
    // A load always wins over an advance in the same cycle.
    ctrlOut.stepEn = ~ctrlOut.loadEn & ~advanceN;
  end
endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burstCtrl_t        ctrlIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int UPPER_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     baseReg;
  logic [BURST_BITS-1:0] beatCnt;
  logic [BURST_BITS-1:0] baseLow;
  logic [BURST_BITS-1:0] linLow;
  logic [BURST_BITS-1:0] ilvLow;
  logic [BURST_BITS-1:0] outLow;
  logic [UPPER_W-1:0]    baseHigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg <= '0;
      beatCnt <= '0;
    end else if (ctrlIn.loadEn) begin
      baseReg <= addrIn;
      beatCnt <= '0;
    end else if (ctrlIn.stepEn) begin
      beatCnt <= beatCnt + 1'b1;  // wraps within BURST_BITS
    end
  end

  always_comb begin
    baseLow  = baseReg[BURST_BITS-1:0];
    baseHigh = baseReg[ADDR_W-1:BURST_BITS];
    linLow   = baseLow + beatCnt;  // truncated: no carry into upper bits
    ilvLow   = baseLow ^ beatCnt;
    outLow   = interleaveSel ? ilvLow : linLow;
    wordAddr = {baseHigh, outLow};
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipEnN,
  input  logic              advanceN,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] wordAddr
);
  burstCtrl_t ctrlBus;

  burst_addr_ctrl u_ctrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .chipEnN     (chipEnN),
    .advanceN    (advanceN),
    .ctrlOut     (ctrlBus)
  );

  burst_addr_dp #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrlIn        (ctrlBus),
    .addrIn        (addrIn),
    .interleaveSel (interleaveSel),
    .wordAddr      (wordAddr)
  );
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W     = 15,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              chipEnN,
  input logic              advanceN,
  input logic              interleaveSel,
  input logic [ADDR_W-1:0] wordAddr
);
  logic anyLoad;
  assign anyLoad = ~ctrlStrobeN | (~procStrobeN & ~chipEnN);

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> wordAddr == '0);

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlStrobeN |=> wordAddr == $past(addrIn));

  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !chipEnN) |=> wordAddr == $past(addrIn));

  // R3
  proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && chipEnN && ctrlStrobeN && advanceN) |=> $stable(wordAddr));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyLoad && advanceN) |=> $stable(wordAddr));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !anyLoad |=> $stable(wordAddr[ADDR_W-1:BURST_BITS]));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyLoad && !advanceN && !interleaveSel)
      |=> wordAddr[BURST_BITS-1:0] == BURST_BITS'($past(wordAddr[BURST_BITS-1:0]) + 1'b1));
endmodule

bind burst_addr_gen burst_addr_chk #(
  .ADDR_W     (ADDR_W),
  .BURST_BITS (BURST_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addrIn        (addrIn),
  .procStrobeN   (procStrobeN),
  .ctrlStrobeN   (ctrlStrobeN),
  .chipEnN       (chipEnN),
  .advanceN      (advanceN),
  .interleaveSel (interleaveSel),
  .wordAddr      (wordAddr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          chipEnN = 1'b1;
  logic          advanceN = 1'b1;
  logic          interleaveSel = 1'b1;
  logic [AW-1:0] wordAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .chipEnN(chipEnN), .advanceN(advanceN),
    .interleaveSel(interleaveSel), .wordAddr(wordAddr)
  );

  // Spec-level model of the beat address.
  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] st, input int n, input bit ilv);
    logic [1:0] c;
    logic [1:0] lo;
    c  = 2'(n);
    lo = ilv ? (st[1:0] ^ c) : 2'(st[1:0] + c);
    return {st[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // One clock edge, then sample 1 time unit later (clock high, away from edge).
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1; chipEnN = 1'b1;
  endtask

  task automatic ctrlLoad(input logic [AW-1:0] a);
    addrIn = a; ctrlStrobeN = 1'b0; advanceN = 1'b1;
    tick();
    ctrlStrobeN = 1'b1;
  endtask

  task automatic test_reset();
    check("R1", wordAddr, '0);
    rst_n = 1'b1;
    tick();
    check("R1", wordAddr, '0);
  endtask

  task automatic test_ctrl_load();
    chipEnN = 1'b1;
    ctrlLoad(15'h1235);
    check("R2", wordAddr, 15'h1235);
    chipEnN = 1'b0;
    ctrlLoad(15'h4321);
    check("R2", wordAddr, 15'h4321);
    idle();
  endtask

  task automatic test_proc_gate();
    addrIn = 15'h2AB6; procStrobeN = 1'b0; chipEnN = 1'b1;
    tick();
    check("R3", wordAddr, 15'h4321);
    chipEnN = 1'b0;
    tick();
    check("R3", wordAddr, 15'h2AB6);
    idle();
  endtask

  task automatic test_interleave();
    interleaveSel = 1'b1;
    ctrlLoad(15'h7FFD);
    check("R6", wordAddr, 15'h7FFD);
    advanceN = 1'b0;
    for (int i = 1; i < 4; i++) begin
      tick();
      check("R6", wordAddr, beatAddr(15'h7FFD, i, 1'b1));
    end
    tick();
    check("R8", wordAddr, 15'h7FFD);
    idle();
  endtask

  task automatic test_linear();
    interleaveSel = 1'b0;
    ctrlLoad(15'h0006);
    check("R7", wordAddr, 15'h0006);
    advanceN = 1'b0;
    for (int i = 1; i < 4; i++) begin
      tick();
      check("R7", wordAddr, beatAddr(15'h0006, i, 1'b0));
    end
    tick();
    check("R8", wordAddr, 15'h0006);
    idle();
  endtask

  task automatic test_suspend();
    interleaveSel = 1'b0;
    ctrlLoad(15'h0101);
    advanceN = 1'b0;
    tick();
    check("R4", wordAddr, 15'h0102);
    advanceN = 1'b1;
    tick(); tick();
    check("R5", wordAddr, 15'h0102);
    advanceN = 1'b0;
    tick();
    check("R4", wordAddr, 15'h0103);
    idle();
  endtask

  task automatic test_priority();
    interleaveSel = 1'b1;
    ctrlLoad(15'h0040);
    advanceN = 1'b0;
    tick();
    check("R9", wordAddr, 15'h0041);
    addrIn = 15'h0C02; chipEnN = 1'b0; procStrobeN = 1'b0;
    tick();
    check("R9", wordAddr, 15'h0C02);
    procStrobeN = 1'b1;
    tick();
    check("R9", wordAddr, beatAddr(15'h0C02, 1, 1'b1));
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    test_ctrl_load();
    test_proc_gate();
    test_interleave();
    test_linear();
    test_suspend();
    test_priority();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule